// File: doc/BRIEF.md
# Zero-Crossing Sub-Sample Interpolator with Tracking Window

This block refines the timing of a tracked zero crossing in a sampled pulse beyond the 1 µs sample grid. For each measurement it takes three band-pass filtered values: the sample just before the tracked one, the tracked sample itself (the one of smallest magnitude next to the crossing), and the sample just after. It forms the fixed-point ratio of the tracked value to the difference of its two neighbours with a bit-serial divider. It maps that ratio through a computed, gently curved lookup table to a signed offset in nanoseconds.

Alongside the timing result the block supervises the tracking index, which is the position of the tracked sample inside the acquisition window. The index may wander inside a hysteresis band around its nominal position. Once it leaves that band, the block asks for the window to be realigned and supplies the nominal index as the new value. Both results are delivered together, in a single-cycle result pulse per accepted measurement.

Top module: `zc_interp_tracker`

## Requirements
- R1: After a synchronous active-low reset, res_valid, sat, div_zero and realign are 0, offset_ns is 0 and next_idx is 75.
- R2: For an accepted strobe with d = f_after − f_before ≠ 0, the block forms q = (f_near · 2048) / d, with the quotient truncated toward zero. The result pulse appears exactly once, on the 28th rising edge after the edge that accepted the strobe.
- R3: For −588 ≤ q ≤ 549 the table address is a = q + 588, and offset_ns = −337 + (1001·a)/1137 − (64·a·(1137−a))/(1137·1137), with each division truncating. The offset therefore always lies in −337..664 ns.
- R4: If q < −588, offset_ns is −337 (address 0). If q > 549, offset_ns is 664 (address 1137). In both cases sat is 1. It is 0 otherwise.
- R5: If f_after equals f_before, the result pulse carries div_zero = 1 and sat = 0, and offset_ns keeps the value of the previous result (or the reset value).
- R6: A strobe that arrives while a measurement is still in progress is ignored. It produces no result pulse and does not alter the pending result.
- R7: With the band 65..85 around nominal index 75: an index inside the band (bounds included) gives realign = 0 and next_idx equal to the input index. An index outside the band gives realign = 1 and next_idx = 75.
- R8: res_valid is a one-cycle pulse, and each accepted strobe yields exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Measurement strobe |
| f_before | input | 16 | Filtered sample preceding the tracked one (signed) |
| f_near | input | 16 | Filtered tracked sample (signed) |
| f_after | input | 16 | Filtered sample following the tracked one (signed) |
| track_idx | input | 8 | Current tracking index in the window |
| res_valid | output | 1 | Result pulse |
| offset_ns | output | 12 | Sub-sample offset in ns (signed) |
| sat | output | 1 | Ratio fell outside the table and was clamped |
| div_zero | output | 1 | Neighbour difference was zero; offset held |
| next_idx | output | 8 | Tracking index to use next |
| realign | output | 1 | Window must be re-centred |

## Verification
The timing path and the window supervision report in the same result pulse. The interesting collisions are therefore a clamped or zero-denominator ratio that coincides with an index outside the band. The bench pairs saturating ratios, exact table-edge quotients and equal neighbours with indices just inside, just outside and far outside the band. The scoreboard judges every field of that one pulse against the requirement formulas, and it checks that a held offset survives a realign.

// File: rtl/zc_interp_pkg.sv
// Package: shared helper for the zero-crossing interpolator.
// Holds the table-entry function so ROM and any reviewer use one definition.
package zc_interp_pkg;

    // Offset in ns for table address a: linear span plus a parabolic bow
    // that is zero at both ends. All divided terms are non-negative.
    function automatic int zc_table_entry(int a, int span, int ns_lo, int ns_hi, int bow);
        int lin;
        int curve;
        lin   = ((ns_hi - ns_lo) * a) / span;
        curve = (bow * 4 * a * (span - a)) / (span * span);
        return ns_lo + lin - curve;
    endfunction

endpackage

// File: rtl/zc_serial_div.sv
// Unsigned restoring divider, one quotient bit per cycle.
// Assumes start is only honoured while idle; den = 0 yields all-ones
// (the caller flags that case). done pulses one cycle with quo final.
module zc_serial_div #(
    parameter int NW = 27,
    parameter int DW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          busy,
    output logic          done,
    output logic [NW-1:0] quo
);
    localparam int RW = DW + 1;
    localparam int CW = $clog2(NW + 1);

    logic [RW-1:0] rem;
    logic [NW-1:0] num_sh;
    logic [DW-1:0] den_r;
    logic [CW-1:0] cnt;
    logic [RW-1:0] trial;
    logic          fits;

    // Trial subtraction for the current bit.
    always_comb begin
        trial = {rem[RW-2:0], num_sh[NW-1]};
        fits  = trial >= {1'b0, den_r};
    end

    // Iteration state: load on start, then shift one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            cnt    <= '0;
            rem    <= '0;
            num_sh <= '0;
            den_r  <= '0;
            quo    <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy   <= 1'b1;
                cnt    <= CW'(NW);
                rem    <= '0;
                num_sh <= num;
                den_r  <= den;
                quo    <= '0;
            end else if (busy) begin
                rem    <= fits ? (trial - {1'b0, den_r}) : trial;
                num_sh <= num_sh << 1;
                quo    <= {quo[NW-2:0], fits};
                cnt    <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/zc_offset_rom.sv
// Constant ratio-to-nanosecond table, filled at elaboration from
// zc_table_entry. Assumes addr < QMAX-QMIN+1; other codes read entry 0.
module zc_offset_rom
    import zc_interp_pkg::*;
#(
    parameter int QMIN  = -588,
    parameter int QMAX  = 549,
    parameter int NS_LO = -337,
    parameter int NS_HI = 664,
    parameter int BOW   = 16,
    parameter int OW    = 12,
    parameter int AW    = 11
) (
    input  logic [AW-1:0]        addr,
    output logic signed [OW-1:0] ns
);
    localparam int N    = QMAX - QMIN + 1;
    localparam int SPAN = N - 1;

    logic signed [OW-1:0] table_q [N];

    // One constant per entry.
    for (genvar g = 0; g < N; g++) begin : g_entry
        assign table_q[g] = OW'(zc_table_entry(g, SPAN, NS_LO, NS_HI, BOW));
    end

    // Read port with guard for unused codes.
    always_comb begin
        if (int'(addr) < N) ns = table_q[addr];
        else                ns = table_q[0];
    end
endmodule

// File: rtl/zc_track_window.sv
// Hysteresis check on the tracking index. Inside NOMINAL +/- DRIFT
// (bounds included) the index passes through; outside it is reset
// to NOMINAL and a realignment is requested. Purely combinational.
module zc_track_window #(
    parameter int IW      = 8,
    parameter int NOMINAL = 75,
    parameter int DRIFT   = 10
) (
    input  logic [IW-1:0] idx,
    output logic          realign,
    output logic [IW-1:0] next_idx
);
    localparam int LO = NOMINAL - DRIFT;
    localparam int HI = NOMINAL + DRIFT;

    // Band test and replacement index.
    always_comb begin
        realign  = (int'(idx) < LO) || (int'(idx) > HI);
        next_idx = realign ? IW'(NOMINAL) : idx;
    end
endmodule

// File: rtl/zc_interp_tracker.sv
// Top: sub-sample zero-crossing interpolator with tracking window.
// Accepts a strobe only when idle, divides |near|<<FRAC by |after-before|,
// applies the sign, clamps to the table range, looks up the ns offset and
// registers it with the window decision. Assumes f_* are two's complement.
module zc_interp_tracker #(
    parameter int W       = 16,
    parameter int FRAC    = 11,
    parameter int QMIN    = -588,
    parameter int QMAX    = 549,
    parameter int NS_LO   = -337,
    parameter int NS_HI   = 664,
    parameter int BOW     = 16,
    parameter int OW      = 12,
    parameter int IW      = 8,
    parameter int NOMINAL = 75,
    parameter int DRIFT   = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [W-1:0]  f_before,
    input  logic signed [W-1:0]  f_near,
    input  logic signed [W-1:0]  f_after,
    input  logic [IW-1:0]        track_idx,
    output logic                 res_valid,
    output logic signed [OW-1:0] offset_ns,
    output logic                 sat,
    output logic                 div_zero,
    output logic [IW-1:0]        next_idx,
    output logic                 realign
);
    localparam int QW = W + FRAC;
    localparam int N  = QMAX - QMIN + 1;
    localparam int AW = $clog2(N);
    localparam logic signed [QW:0]   QLO = (QW+1)'(QMIN);
    localparam logic signed [QW:0]   QHI = (QW+1)'(QMAX);
    localparam logic signed [OW-1:0] NSL = OW'(NS_LO);
    localparam logic signed [OW-1:0] NSH = OW'(NS_HI);

    logic signed [W:0]   diff;
    logic [W-1:0]        near_mag;
    logic [W:0]          den_mag;
    logic [QW-1:0]       num_mag;
    logic                accept;
    logic                div_busy;
    logic                div_done;
    logic [QW-1:0]       quo;
    logic                neg_r;
    logic                zero_r;
    logic [IW-1:0]       idx_r;
    logic signed [QW:0]  q_s;
    logic                lo_sat;
    logic                hi_sat;
    logic [AW-1:0]       addr;
    logic signed [OW-1:0] rom_ns;
    logic                win_realign;
    logic [IW-1:0]       win_next;

    // Operand magnitudes for the unsigned divider.
    always_comb begin
        diff     = {f_after[W-1], f_after} - {f_before[W-1], f_before};
        near_mag = f_near[W-1] ? W'(-f_near) : W'(f_near);
        den_mag  = diff[W] ? (W+1)'(-diff) : (W+1)'(diff);
        num_mag  = {near_mag, {FRAC{1'b0}}};
        accept   = in_valid && !div_busy && !div_done;
    end

    zc_serial_div #(.NW(QW), .DW(W+1)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .num   (num_mag),
        .den   (den_mag),
        .busy  (div_busy),
        .done  (div_done),
        .quo   (quo)
    );

    // Side information captured with the accepted measurement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_r  <= 1'b0;
            zero_r <= 1'b0;
            idx_r  <= IW'(NOMINAL);
        end else if (accept) begin
            neg_r  <= f_near[W-1] ^ diff[W];
            zero_r <= (diff == '0);
            idx_r  <= track_idx;
        end
    end

    // Signed quotient, clamp and table address.
    always_comb begin
        q_s    = neg_r ? -$signed({1'b0, quo}) : $signed({1'b0, quo});
        lo_sat = q_s < QLO;
        hi_sat = q_s > QHI;
        if (lo_sat)      addr = '0;
        else if (hi_sat) addr = AW'(N - 1);
        else             addr = AW'(q_s - QLO);
    end

    zc_offset_rom #(
        .QMIN(QMIN), .QMAX(QMAX), .NS_LO(NS_LO), .NS_HI(NS_HI),
        .BOW(BOW), .OW(OW), .AW(AW)
    ) rom_i (
        .addr (addr),
        .ns   (rom_ns)
    );

    zc_track_window #(.IW(IW), .NOMINAL(NOMINAL), .DRIFT(DRIFT)) win_i (
        .idx      (idx_r),
        .realign  (win_realign),
        .next_idx (win_next)
    );

    // Result registers, updated once per finished division.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            offset_ns <= '0;
            sat       <= 1'b0;
            div_zero  <= 1'b0;
            next_idx  <= IW'(NOMINAL);
            realign   <= 1'b0;
        end else begin
            res_valid <= div_done;
            if (div_done) begin
                sat      <= !zero_r && (lo_sat || hi_sat);
                div_zero <= zero_r;
                if (!zero_r) offset_ns <= rom_ns;
                next_idx <= win_next;
                realign  <= win_realign;
            end
        end
    end

    // R3: every delivered offset lies within the table span.
    a_r3_offset_in_span: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (offset_ns >= NSL) && (offset_ns <= NSH));

    // R4: a clamped result sits on one of the end entries.
    a_r4_sat_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && sat |-> (offset_ns == NSL) || (offset_ns == NSH));

    // R5: zero denominator keeps the previous offset and is not saturated.
    a_r5_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && div_zero |-> (offset_ns == $past(offset_ns)) && !sat);

    // R7: a realignment always returns the nominal index.
    a_r7_recentre: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && realign |-> next_idx == IW'(NOMINAL));

    // R7: without realignment the index stays inside the band.
    a_r7_in_band: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !realign |-> (int'(next_idx) >= NOMINAL - DRIFT) &&
                                   (int'(next_idx) <= NOMINAL + DRIFT));

    // R8: the result strobe lasts one cycle.
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
endmodule

// File: tb/zc_interp_tracker_tb_top.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops
// and compares them on every result pulse.
module zc_interp_tracker_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [15:0] f_before = '0;
    logic signed [15:0] f_near = '0;
    logic signed [15:0] f_after = '0;
    logic [7:0]        track_idx = 8'd75;
    logic              res_valid;
    logic signed [11:0] offset_ns;
    logic              sat;
    logic              div_zero;
    logic [7:0]        next_idx;
    logic              realign;

    typedef struct {
        longint off;
        bit     sat;
        bit     zero;
        int     idx;
        bit     realign;
        string  tag;
    } exp_t;

    exp_t   sb_q[$];
    int     checks = 0;
    int     errors = 0;
    longint last_off = 0;
    bit     finished = 1'b0;

    always #4 clk = ~clk;

    zc_interp_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .f_before(f_before), .f_near(f_near), .f_after(f_after),
        .track_idx(track_idx), .res_valid(res_valid), .offset_ns(offset_ns),
        .sat(sat), .div_zero(div_zero), .next_idx(next_idx), .realign(realign)
    );

    // Table formula from R3.
    function automatic longint model_ns(longint a);
        return -337 + (1001 * a) / 1137 - (64 * a * (1137 - a)) / (1137 * 1137);
    endfunction

    // Driver: compute the expected result, push it, strobe once, wait.
    task automatic send(input int fb, input int fn, input int fa, input int idx, input string tag);
        exp_t   e;
        longint d;
        longint q;
        longint a;
        d = longint'(fa) - longint'(fb);
        e.tag = tag;
        e.zero = (d == 0);
        e.sat = 1'b0;
        if (d == 0) begin
            e.off = last_off;
        end else begin
            q = (longint'(fn) * 2048) / d;
            if (q < -588)     begin a = 0;    e.sat = 1'b1; end
            else if (q > 549) begin a = 1137; e.sat = 1'b1; end
            else              a = q + 588;
            e.off = model_ns(a);
            last_off = e.off;
        end
        e.realign = (idx < 65) || (idx > 85);
        e.idx = e.realign ? 75 : idx;
        sb_q.push_back(e);
        @(negedge clk);
        f_before = 16'(fb); f_near = 16'(fn); f_after = 16'(fa);
        track_idx = 8'(idx); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (34) @(negedge clk);
    endtask

    // Monitor: compare every result pulse against the scoreboard head.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (res_valid) begin
                checks++;
                if (sb_q.size() == 0) begin
                    errors++;
                    $display("FAIL R8/R6 unexpected result: off=%0d idx=%0d expected none",
                             offset_ns, next_idx);
                end else begin
                    e = sb_q.pop_front();
                    if (longint'(offset_ns) != e.off || sat != e.sat || div_zero != e.zero ||
                        int'(next_idx) != e.idx || realign != e.realign) begin
                        errors++;
                        $display("FAIL %s: off=%0d sat=%0b zero=%0b idx=%0d realign=%0b expected off=%0d sat=%0b zero=%0b idx=%0d realign=%0b",
                                 e.tag, offset_ns, sat, div_zero, next_idx, realign,
                                 e.off, e.sat, e.zero, e.idx, e.realign);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R8 watchdog expired: pending=%0d expected 0", sb_q.size());
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;  // R1 reset state
        if (res_valid || sat || div_zero || realign || offset_ns != 0 || next_idx != 8'd75) begin
            errors++;
            $display("FAIL R1 reset: valid=%0b sat=%0b zero=%0b realign=%0b off=%0d idx=%0d expected 0 0 0 0 0 75",
                     res_valid, sat, div_zero, realign, offset_ns, next_idx);
        end

        // R5: zero denominator straight after reset holds the reset offset.
        send(700, 123, 700, 75, "R5 zero after reset");
        // R2/R3: in-range ratios of both signs and zero.
        send(1000, 100, -1000, 75, "R2 R3 negative ratio");
        send(-2000, -300, 2000, 80, "R3 negative numerator");
        send(-2000, 0, 2000, 70, "R3 zero numerator");
        send(-400, -50, 300, 75, "R2 both negative");
        // R4: exact table edges and one past them.
        send(0, 549, 2048, 75, "R4 upper edge q=549");
        send(0, 550, 2048, 75, "R4 above upper edge");
        send(0, -588, 2048, 75, "R4 lower edge q=-588");
        send(0, -589, 2048, 75, "R4 below lower edge");
        send(50, 5000, -50, 75, "R4 deep negative");
        send(32767, -32768, -32768, 75, "R4 extreme operands");
        // R7: band edges and far outside.
        send(-2000, 100, 2000, 85, "R7 upper bound inside");
        send(-2000, 100, 2000, 86, "R7 just above band");
        send(-2000, 100, 2000, 65, "R7 lower bound inside");
        send(-2000, 100, 2000, 64, "R7 just below band");
        send(-2000, 100, 2000, 0, "R7 index zero");
        // Collisions: clamp or zero-hold with realignment.
        send(0, 900, 1000, 200, "R4 R7 sat with realign");
        send(-5, 77, -5, 90, "R5 R7 zero hold with realign");

        // R6: a strobe during the computation is ignored.
        begin
            exp_t e;
            e.off = model_ns(longint'((longint'(200) * 2048) / 4000) + 588);
            last_off = e.off;
            e.sat = 1'b0; e.zero = 1'b0; e.idx = 75; e.realign = 1'b0;
            e.tag = "R6 busy strobe ignored";
            sb_q.push_back(e);
            @(negedge clk);
            f_before = -16'sd2000; f_near = 16'sd200; f_after = 16'sd2000;
            track_idx = 8'd75; in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            repeat (5) @(negedge clk);
            f_before = 16'sd0; f_near = 16'sd900; f_after = 16'sd1000;
            track_idx = 8'd3; in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            repeat (60) @(negedge clk);
        end
        send(-1000, 40, 1000, 76, "R2 after ignored strobe");

        repeat (40) @(negedge clk);
        checks++;  // R8 every accepted strobe produced its result
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R8 missing results: pending=%0d expected 0", sb_q.size());
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule